// File: doc/BRIEF.md
# Thread Block Dispatcher

This block spreads a one-dimensional grid of thread blocks across a fixed set of multiprocessor slots. A launch gives it two values: the element count and the threads per block. It accepts the launch through a valid/ready handshake. It then walks the grid one block at a time. Each block goes to the lowest-numbered slot that is idle at that moment, so the order of assignment follows the order in which slots drain rather than any fixed schedule. A block always lands whole on one slot.

The block reports every grant. The report carries the slot number, the block number, the global index of the block's first thread, and how many of its threads are live. Threads whose global index reaches the element count are left out of that live count, so the final block of a grid that does not divide evenly comes out partly masked. The number of blocks is the ceiling of the element count over the block size. A slot signals with a one-cycle retire pulse that its block has finished. Once every block has been issued and has retired, the dispatcher raises a done flag and becomes ready for the next launch.

Top module: `tbd_dispatcher`

## Requirements
- R1: While reset is held and in the first cycle after it, `launch_ready` is 1, `done` is 0, `grant_valid` is 0 and every bit of `slot_busy` is 0.
- R2: A launch is taken in a cycle where `launch_valid` and `launch_ready` are both 1. `launch_ready` is 0 from the next cycle until the grid completes, and launches offered during that time have no effect.
- R3: A grant is made only when a slot is idle, and it always goes to the lowest-numbered idle slot. At most one grant is made per cycle. The chosen slot's `slot_busy` bit reads 1 from the next cycle.
- R4: Blocks are issued in ascending order starting at 0. Block k reports `grant_base` = k × threads-per-block.
- R5: `grant_active` equals the smaller of the threads per block and (element count − `grant_base`). A grid issues exactly ceil(elements / threads-per-block) blocks.
- R6: A `retire` pulse on a busy slot clears its busy bit on the next cycle, and that slot may be granted again from then on. A `retire` pulse on an idle slot has no effect.
- R7: `done` rises in the cycle after the retire that leaves no block outstanding and none left to issue. `launch_ready` rises at the same time. `done` stays 1 until the next launch is taken.
- R8: A launch with an element count of 0 or a threads-per-block of 0 issues no blocks, and `done` rises two cycles after the launch is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| launch_valid | input | 1 | Launch descriptor offered |
| launch_ready | output | 1 | Dispatcher idle, launch can be taken |
| launch_elems | input | CNT_W | Total element (thread) count of the grid |
| launch_tpb | input | TPB_W | Threads per block |
| retire | input | NUM_SLOTS | Per-slot pulse: its block has finished |
| slot_busy | output | NUM_SLOTS | Per-slot occupancy |
| grant_valid | output | 1 | A block is handed out this cycle |
| grant_slot | output | SLOT_W | Slot that receives the block |
| grant_block | output | CNT_W | Block index within the grid |
| grant_base | output | CNT_W | Global index of the block's first thread |
| grant_active | output | TPB_W | Live threads in the block |
| done | output | 1 | Whole grid issued and retired |

## Verification
If the busy bits are wrong, a grant goes to the wrong slot, or to a slot that is still occupied, within one cycle, and `slot_busy` shows the error at the same time. If the grid cursor is wrong, `grant_base`, `grant_block` or `grant_active` are wrong on the next grant. It also changes the total block count, and that shows when `done` rises too early or too late. The bench compares every one of these outputs on every cycle against a behavioural model. It does this while slot lifetimes vary, while retire pulses hit idle slots, and while launches are offered mid-grid, so a divergence appears in the cycle it starts.

// File: rtl/tbd_pkg.sv
package tbd_pkg;

  // Live threads in a block starting at base: min(tpb, elems - base).
  function automatic int unsigned tail_count(int unsigned base,
                                             int unsigned tpb,
                                             int unsigned elems);
    int unsigned rem;
    rem = (elems > base) ? (elems - base) : 0;
    return (rem < tpb) ? rem : tpb;
  endfunction

  // Blocks a grid needs: ceil(elems / tpb), zero for an empty launch.
  function automatic int unsigned grid_blocks(int unsigned elems,
                                              int unsigned tpb);
    if (tpb == 0) return 0;
    return (elems + tpb - 1) / tpb;
  endfunction

endpackage

// File: rtl/tbd_pick.sv
module tbd_pick #(
  parameter int N = 4,
  localparam int SW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  free_mask,
  output logic          any_free,
  output logic [N-1:0]  pick_onehot,
  output logic [SW-1:0] pick_idx
);

  always_comb begin
    pick_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (free_mask[i]) pick_idx = SW'(i);
    end
  end

  assign pick_onehot = free_mask & (~free_mask + N'(1));
  assign any_free    = |free_mask;

endmodule

// File: rtl/tbd_slots.sv
module tbd_slots #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         alloc_en,
  input  logic [N-1:0] alloc_onehot,
  input  logic [N-1:0] retire,
  output logic [N-1:0] busy,
  output logic [N-1:0] retire_hit
);

  for (genvar g = 0; g < N; g++) begin : g_slot
    logic occ_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          occ_q <= 1'b0;
      else if (alloc_en && alloc_onehot[g]) occ_q <= 1'b1;
      else if (retire[g])                   occ_q <= 1'b0;
    end
    assign busy[g] = occ_q;
  end

  assign retire_hit = retire & busy;

endmodule

// File: rtl/tbd_cursor.sv
module tbd_cursor #(
  parameter int CNT_W = 16,
  parameter int TPB_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] elems_in,
  input  logic [TPB_W-1:0] tpb_in,
  input  logic             advance,
  output logic             more,
  output logic [CNT_W-1:0] base,
  output logic [CNT_W-1:0] blk,
  output logic [TPB_W-1:0] active,
  output logic [TPB_W-1:0] tpb_cur
);
  import tbd_pkg::*;

  logic [CNT_W:0]   base_q;
  logic [CNT_W-1:0] blk_q;
  logic [CNT_W-1:0] elems_q;
  logic [TPB_W-1:0] tpb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      blk_q   <= '0;
      elems_q <= '0;
      tpb_q   <= '0;
    end else if (load) begin
      base_q  <= '0;
      blk_q   <= '0;
      elems_q <= elems_in;
      tpb_q   <= tpb_in;
    end else if (advance) begin
      base_q  <= base_q + (CNT_W+1)'(tpb_q);
      blk_q   <= blk_q + CNT_W'(1);
    end
  end

  assign more    = (tpb_q != '0) && (base_q < {1'b0, elems_q});
  assign base    = base_q[CNT_W-1:0];
  assign blk     = blk_q;
  assign tpb_cur = tpb_q;
  assign active  = TPB_W'(tail_count(32'(base_q), 32'(tpb_q), 32'(elems_q)));

endmodule

// File: rtl/tbd_dispatcher.sv
module tbd_dispatcher #(
  parameter int NUM_SLOTS = 4,
  parameter int CNT_W     = 16,
  parameter int TPB_W     = 11,
  localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 launch_valid,
  output logic                 launch_ready,
  input  logic [CNT_W-1:0]     launch_elems,
  input  logic [TPB_W-1:0]     launch_tpb,
  input  logic [NUM_SLOTS-1:0] retire,
  output logic [NUM_SLOTS-1:0] slot_busy,
  output logic                 grant_valid,
  output logic [SLOT_W-1:0]    grant_slot,
  output logic [CNT_W-1:0]     grant_block,
  output logic [CNT_W-1:0]     grant_base,
  output logic [TPB_W-1:0]     grant_active,
  output logic                 done
);

  logic                 running_q;
  logic                 done_q;
  logic                 launch_take;
  logic                 blocks_left;
  logic                 any_free;
  logic [NUM_SLOTS-1:0] pick_onehot;
  logic [NUM_SLOTS-1:0] retire_hit;
  logic                 finish_evt;
  logic [TPB_W-1:0]     cur_tpb;

  assign launch_ready = !running_q;
  assign launch_take  = launch_valid && launch_ready;

  tbd_cursor #(.CNT_W(CNT_W), .TPB_W(TPB_W)) u_cursor (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (launch_take),
    .elems_in (launch_elems),
    .tpb_in   (launch_tpb),
    .advance  (grant_valid),
    .more     (blocks_left),
    .base     (grant_base),
    .blk      (grant_block),
    .active   (grant_active),
    .tpb_cur  (cur_tpb)
  );

  tbd_pick #(.N(NUM_SLOTS)) u_pick (
    .free_mask   (~slot_busy),
    .any_free    (any_free),
    .pick_onehot (pick_onehot),
    .pick_idx    (grant_slot)
  );

  tbd_slots #(.N(NUM_SLOTS)) u_slots (
    .clk          (clk),
    .rst_n        (rst_n),
    .alloc_en     (grant_valid),
    .alloc_onehot (pick_onehot),
    .retire       (retire),
    .busy         (slot_busy),
    .retire_hit   (retire_hit)
  );

  assign grant_valid = running_q && blocks_left && any_free;
  assign finish_evt  = running_q && !blocks_left &&
                       ((slot_busy & ~retire_hit) == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running_q <= 1'b0;
      done_q    <= 1'b0;
    end else if (launch_take) begin
      running_q <= 1'b1;
      done_q    <= 1'b0;
    end else if (finish_evt) begin
      running_q <= 1'b0;
      done_q    <= 1'b1;
    end
  end

  assign done = done_q;

endmodule

// File: rtl/tbd_dispatcher_chk.sv
module tbd_dispatcher_chk #(
  parameter int NUM_SLOTS = 4,
  parameter int TPB_W     = 11,
  localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 launch_valid,
  input logic                 launch_ready,
  input logic [NUM_SLOTS-1:0] retire,
  input logic [NUM_SLOTS-1:0] slot_busy,
  input logic                 grant_valid,
  input logic [SLOT_W-1:0]    grant_slot,
  input logic [TPB_W-1:0]     grant_active,
  input logic [TPB_W-1:0]     cur_tpb,
  input logic                 done
);

  logic [NUM_SLOTS-1:0] below;
  assign below = (NUM_SLOTS'(1) << grant_slot) - NUM_SLOTS'(1);

  a_r3_grant_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> !slot_busy[grant_slot]);

  a_r3_lowest_idle: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> ((slot_busy & below) == below));

  a_r3_busy_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |=> slot_busy[$past(grant_slot)]);

  a_r5_active_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> (grant_active != '0 && grant_active <= cur_tpb));

  a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> !launch_ready);

  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (slot_busy == '0 && launch_ready));

  a_r7_done_held: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done) |-> $past(launch_valid));

  a_r7_done_after_retire: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(slot_busy & ~retire) == '0));

endmodule

bind tbd_dispatcher tbd_dispatcher_chk #(.NUM_SLOTS(NUM_SLOTS), .TPB_W(TPB_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .launch_valid (launch_valid),
  .launch_ready (launch_ready),
  .retire       (retire),
  .slot_busy    (slot_busy),
  .grant_valid  (grant_valid),
  .grant_slot   (grant_slot),
  .grant_active (grant_active),
  .cur_tpb      (cur_tpb),
  .done         (done)
);

// File: tb/tbd_dispatcher_tb.sv
`timescale 1ns/1ps
module tbd_dispatcher_tb;
  localparam int NS = 4;
  localparam int CW = 16;
  localparam int TW = 11;
  localparam int SW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          launch_valid = 1'b0;
  logic          launch_ready;
  logic [CW-1:0] launch_elems = '0;
  logic [TW-1:0] launch_tpb = '0;
  logic [NS-1:0] retire = '0;
  logic [NS-1:0] slot_busy;
  logic          grant_valid;
  logic [SW-1:0] grant_slot;
  logic [CW-1:0] grant_block;
  logic [CW-1:0] grant_base;
  logic [TW-1:0] grant_active;
  logic          done;

  always #2.5 clk = ~clk;

  tbd_dispatcher #(.NUM_SLOTS(NS), .CNT_W(CW), .TPB_W(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .launch_valid(launch_valid), .launch_ready(launch_ready),
    .launch_elems(launch_elems), .launch_tpb(launch_tpb), .retire(retire),
    .slot_busy(slot_busy), .grant_valid(grant_valid), .grant_slot(grant_slot),
    .grant_block(grant_block), .grant_base(grant_base), .grant_active(grant_active),
    .done(done)
  );

  int checks = 0;
  int errors = 0;

  // behavioural model state
  int m_run = 0, m_done = 0, m_elems = 0, m_tpb = 0, m_base = 0, m_blk = 0;
  int m_busy[NS];
  int life[NS];
  int pend = 0, p_elems = 0, p_tpb = 0;
  int junk = 0, stray = 0, grants = 0, cyc = 0;

  task automatic cmp(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic step();
    logic [NS-1:0] r;
    int more, fs, gv, idle, acc, exp_act;
    @(negedge clk);
    r = '0;
    for (int i = 0; i < NS; i++) begin
      if (m_busy[i] != 0) begin
        if (life[i] == 0) r[i] = 1'b1;
        else life[i]--;
      end else if (stray != 0 && ((cyc + i) % 3 == 0)) begin
        r[i] = 1'b1;  // R6: pulse on an idle slot must be ignored
      end
    end
    retire = r;
    launch_valid = (pend != 0) || (junk != 0 && m_run != 0);
    launch_elems = (pend != 0) ? CW'(p_elems) : CW'(77);
    launch_tpb   = (pend != 0) ? TW'(p_tpb) : TW'(5);
    #1;
    more = (m_tpb != 0 && m_base < m_elems) ? 1 : 0;
    fs = -1;
    for (int i = NS - 1; i >= 0; i--) if (m_busy[i] == 0) fs = i;
    gv = (m_run != 0 && more != 0 && fs >= 0) ? 1 : 0;
    cmp("R2 launch_ready", int'(launch_ready), (m_run == 0) ? 1 : 0);
    cmp("R7 done", int'(done), m_done);
    cmp("R3 grant_valid", int'(grant_valid), gv);
    if (gv != 0) begin
      exp_act = (m_elems - m_base < m_tpb) ? (m_elems - m_base) : m_tpb;
      cmp("R3 grant_slot", int'(grant_slot), fs);
      cmp("R4 grant_block", int'(grant_block), m_blk);
      cmp("R4 grant_base", int'(grant_base), m_base);
      cmp("R5 grant_active", int'(grant_active), exp_act);
    end
    for (int i = 0; i < NS; i++) cmp("R6 slot_busy", int'(slot_busy[i]), m_busy[i]);
    // advance the model
    acc = (launch_valid && m_run == 0) ? 1 : 0;
    for (int i = 0; i < NS; i++) if (r[i]) m_busy[i] = 0;
    if (gv != 0) begin
      m_busy[fs] = 1;
      life[fs] = (m_blk * 5 + 2) % 4;
      m_base += m_tpb;
      m_blk++;
      grants++;
    end
    idle = 1;
    for (int i = 0; i < NS; i++) if (m_busy[i] != 0) idle = 0;
    if (m_run != 0 && more == 0 && idle != 0) begin
      m_run = 0;
      m_done = 1;
    end
    if (acc != 0) begin
      m_run = 1; m_done = 0; m_elems = p_elems; m_tpb = p_tpb;
      m_base = 0; m_blk = 0; pend = 0; grants = 0;
    end
    cyc++;
  endtask

  task automatic run_grid(int e, int t, int j, int s);
    int k, exp_blocks;
    p_elems = e; p_tpb = t; pend = 1; junk = j; stray = s;
    k = 0;
    while (!(m_done != 0 && pend == 0) && k < 4000) begin
      step();
      k++;
    end
    if (k >= 4000) begin
      errors++;
      $display("FAIL R7 grid %0d/%0d never completed actual=0 expected=1", e, t);
    end
    exp_blocks = (t == 0) ? 0 : (e + t - 1) / t;
    cmp(e == 0 || t == 0 ? "R8 block count" : "R5 block count", grants, exp_blocks);
    junk = 0; stray = 0;
    repeat (3) step();
  endtask

  initial begin
    for (int i = 0; i < NS; i++) begin m_busy[i] = 0; life[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    cmp("R1 reset ready", int'(launch_ready), 1);
    cmp("R1 reset done", int'(done), 0);
    cmp("R1 reset grant", int'(grant_valid), 0);
    cmp("R1 reset busy", int'(slot_busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    cmp("R1 after reset ready", int'(launch_ready), 1);
    cmp("R1 after reset busy", int'(slot_busy), 0);
    run_grid(1024, 256, 0, 0);   // R4 even split into four blocks
    run_grid(1000, 256, 0, 0);   // R5 partial tail block
    run_grid(37, 3, 1, 1);       // R2 launches refused mid-grid, R6 stray retires
    run_grid(5, 16, 0, 0);       // R5 single partial block
    run_grid(0, 64, 0, 0);       // R8 empty grid
    run_grid(10, 0, 0, 0);       // R8 zero block size
    run_grid(64, 1, 1, 1);       // R3 many blocks contend for slots
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule